// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds and Replay

This block is a first-in first-out buffer of 512 words, each 18 bits wide, placed between two unrelated clock domains. The producer pushes words on its own free-running clock, and the consumer pulls them on another. A push or a pull happens only on a rising edge of the matching clock while the matching enable is high. The two sides work independently, except that nothing can be pushed while the buffer is full and nothing can be pulled while it is empty.

Five status flags describe the fill level: full, almost-full and half-full on the producer clock, and empty and almost-empty on the consumer clock. The almost-full threshold is a distance from the top of the buffer and the almost-empty threshold is a distance from the bottom. Both distances are 63 after reset, and each can be reloaded from its own domain.

A replay input rewinds only the consumer's read position to storage slot zero, so that the block of words stored since reset can be read again as many times as needed. Replay works only until either position has wrapped past the last slot. After that it is ignored until the next reset. The producer should stay idle for a few cycles around a replay.

Top module: `dcf_fifo`

## Requirements
- R1: Words come out of `rdata` in the order they were accepted, and `rdata` updates on the rising `rclk` edge that accepts the read.
- R2: `full` is high exactly when 512 words are held, and a push attempted while `full` is high changes neither storage nor the count.
- R3: `empty` is high exactly when no word is held, and a pull attempted while `empty` is high leaves `rdata` and the count unchanged.
- R4: `hfull` is high while at least 257 words are held.
- R5: `afull` is high while the count is at least 512 minus the almost-full distance, and that distance resets to 63.
- R6: `aempty` is high while the count is at most the almost-empty distance, and that distance resets to 63.
- R7: A high `af_ld` at a rising `wclk` edge loads `af_val` as the almost-full distance, and a high `ae_ld` at a rising `rclk` edge loads `ae_val` as the almost-empty distance.
- R8: A high `rt` at a rising `rclk` edge, before any wrap, sets the read position to slot zero and leaves the write position alone. A pull requested on the same edge is dropped. The next pull returns the first word stored after reset, and the consumer-side flags follow within two `rclk` cycles.
- R9: Once either position has passed slot 511, `rt` has no effect until reset, and reset makes replay available again.
- R10: After reset `empty` and `aempty` are high, `full`, `afull` and `hfull` are low, and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| rclk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| wen | input | 1 | Push request, sampled on rising `wclk` |
| wdata | input | 18 | Word to push |
| af_ld | input | 1 | Load almost-full distance (wclk) |
| af_val | input | 9 | New almost-full distance |
| ren | input | 1 | Pull request, sampled on rising `rclk` |
| rt | input | 1 | Replay: rewind read position to slot zero (rclk) |
| ae_ld | input | 1 | Load almost-empty distance (rclk) |
| ae_val | input | 9 | New almost-empty distance |
| rdata | output | 18 | Last word pulled |
| full | output | 1 | 512 words held |
| afull | output | 1 | Count at or above the almost-full threshold |
| hfull | output | 1 | At least 257 words held |
| aempty | output | 1 | Count at or below the almost-empty distance |
| empty | output | 1 | No word held |

## Verification
The hardest state to reach from the ports is a replay request that has to be ignored. Reaching it takes more than 512 accepted pushes, so the write position must pass slot 511. The stimulus table does this by filling the buffer to full, draining it and then pushing 300 more words. The bench then issues a replay with one word stored and checks that the count and the next word are both unaffected. A replay asserted together with a pull is also driven, to show that the pull is dropped and that reading resumes from the first stored word.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    parameter int unsigned DCF_DATA_W  = 18;
    parameter int unsigned DCF_ADDR_W  = 9;
    parameter int unsigned DCF_OFF_RST = 63;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = store_q[raddr];
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned OFF_RST = 63,
    localparam int unsigned PTR_W  = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic              af_ld,
    input  logic [ADDR_W-1:0] af_val,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wgray,
    output logic              wwrap,
    output logic              full,
    output logic              afull,
    output logic              hfull
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned HALF  = DEPTH / 2 + 1;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  gray;
        logic [ADDR_W-1:0] off;
        logic              wrap;
        logic              full;
        logic              afull;
        logic              hfull;
    } wst_t;

    wst_t             st_d, st_q;
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] used;

    assign we = wen & ~st_q.full;

    always_comb begin
        rbin[PTR_W-1] = rgray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rgray_s[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        if (af_ld) begin
            st_d.off = af_val;
        end
        st_d.wrap  = st_q.wrap | st_d.ptr[PTR_W-1];
        used       = st_d.ptr - rbin;
        st_d.full  = (used == PTR_W'(DEPTH));
        st_d.afull = (used >= (PTR_W'(DEPTH) - {1'b0, st_d.off}));
        st_d.hfull = (used >= PTR_W'(HALF));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.off <= ADDR_W'(OFF_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr = st_q.ptr[ADDR_W-1:0];
    assign wgray = st_q.gray;
    assign wwrap = st_q.wrap;
    assign full  = st_q.full;
    assign afull = st_q.afull;
    assign hfull = st_q.hfull;

    a_r2_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen && st_q.full) |=> $stable(st_q.ptr));

    a_r5_full_within_afull: assert property (@(posedge wclk) disable iff (!rst_n)
        st_q.full |-> st_q.afull);

    a_r4_full_within_half: assert property (@(posedge wclk) disable iff (!rst_n)
        st_q.full |-> st_q.hfull);

    a_r9_wrap_sticky: assert property (@(posedge wclk) disable iff (!rst_n)
        st_q.wrap |=> st_q.wrap);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned OFF_RST = 63,
    localparam int unsigned PTR_W  = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              ren,
    input  logic              rt,
    input  logic              ae_ld,
    input  logic [ADDR_W-1:0] ae_val,
    input  logic [PTR_W-1:0]  wgray_s,
    input  logic              wwrap_s,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic              empty,
    output logic              aempty
);
    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  gray;
        logic [ADDR_W-1:0] off;
        logic              wrap;
        logic              empty;
        logic              aempty;
    } rst_t;

    rst_t             st_d, st_q;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] held;
    logic             rewind;

    assign rewind = rt & ~st_q.wrap & ~wwrap_s;
    assign re     = ren & ~st_q.empty & ~rewind;

    always_comb begin
        wbin[PTR_W-1] = wgray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_s[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (rewind) begin
            st_d.ptr = '0;
        end else if (re) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        if (ae_ld) begin
            st_d.off = ae_val;
        end
        st_d.wrap   = st_q.wrap | wwrap_s | st_d.ptr[PTR_W-1];
        held        = wbin - st_d.ptr;
        st_d.empty  = (held == '0);
        st_d.aempty = (held <= {1'b0, st_d.off});
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.off    <= ADDR_W'(OFF_RST);
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr  = st_q.ptr[ADDR_W-1:0];
    assign rgray  = st_q.gray;
    assign empty  = st_q.empty;
    assign aempty = st_q.aempty;

    a_r3_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren && st_q.empty && !rt) |=> $stable(st_q.ptr));

    a_r6_empty_within_aempty: assert property (@(posedge rclk) disable iff (!rst_n)
        st_q.empty |-> st_q.aempty);

    a_r8_rewind_to_zero: assert property (@(posedge rclk) disable iff (!rst_n)
        (rt && !st_q.wrap && !wwrap_s) |=> (st_q.ptr == '0));

    a_r9_rt_blocked_after_wrap: assert property (@(posedge rclk) disable iff (!rst_n)
        (rt && st_q.wrap && !ren) |=> $stable(st_q.ptr));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int unsigned DATA_W  = dcf_pkg::DCF_DATA_W,
    parameter int unsigned ADDR_W  = dcf_pkg::DCF_ADDR_W,
    parameter int unsigned OFF_RST = dcf_pkg::DCF_OFF_RST
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    input  logic              af_ld,
    input  logic [ADDR_W-1:0] af_val,
    input  logic              ren,
    input  logic              rt,
    input  logic              ae_ld,
    input  logic [ADDR_W-1:0] ae_val,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              afull,
    output logic              hfull,
    output logic              aempty,
    output logic              empty
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic              we, re, wwrap, wwrap_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
        .rclk(rclk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(rdata)
    );

    dcf_wr_ctl #(.ADDR_W(ADDR_W), .OFF_RST(OFF_RST)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen(wen), .af_ld(af_ld), .af_val(af_val),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray), .wwrap(wwrap),
        .full(full), .afull(afull), .hfull(hfull)
    );

    dcf_rd_ctl #(.ADDR_W(ADDR_W), .OFF_RST(OFF_RST)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren(ren), .rt(rt), .ae_ld(ae_ld), .ae_val(ae_val),
        .wgray_s(wgray_s), .wwrap_s(wwrap_s), .re(re), .raddr(raddr), .rgray(rgray),
        .empty(empty), .aempty(aempty)
    );

    dcf_sync #(.W(PTR_W)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .din(rgray), .dout(rgray_s)
    );

    dcf_sync #(.W(PTR_W + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .din({wwrap, wgray}), .dout({wwrap_s, wgray_s})
    );
endmodule

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
    localparam int DEPTH = 512;

    typedef struct packed {
        int nw;
        int nr;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{nw: 63,  nr: 0},   // 63: aempty edge (R6)
        '{nw: 1,   nr: 0},   // 64
        '{nw: 193, nr: 0},   // 257: half (R4)
        '{nw: 0,   nr: 1},   // 256
        '{nw: 192, nr: 0},   // 448
        '{nw: 1,   nr: 0},   // 449: afull edge (R5)
        '{nw: 62,  nr: 0},   // 511
        '{nw: 1,   nr: 0},   // 512 full (R2)
        '{nw: 3,   nr: 0},   // pushes while full (R2)
        '{nw: 0,   nr: 512}, // drain, order (R1)
        '{nw: 0,   nr: 2},   // pulls while empty (R3)
        '{nw: 300, nr: 0},   // write position wraps
        '{nw: 0,   nr: 300}
    };

    logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic        wen = 1'b0, ren = 1'b0, rt = 1'b0, af_ld = 1'b0, ae_ld = 1'b0;
    logic [17:0] wdata = '0;
    logic [8:0]  af_val = '0, ae_val = '0;
    logic [17:0] rdata;
    logic        full, afull, hfull, aempty, empty;

    dcf_fifo u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen(wen), .wdata(wdata),
        .af_ld(af_ld), .af_val(af_val), .ren(ren), .rt(rt), .ae_ld(ae_ld),
        .ae_val(ae_val), .rdata(rdata), .full(full), .afull(afull), .hfull(hfull),
        .aempty(aempty), .empty(empty)
    );

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    int total = 0, bad = 0;
    bit done = 1'b0;
    int mdata [DEPTH];
    int head = 0, tail = 0, af_m = 63, ae_m = 63, next_val = 1;
    int last_rd = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen   = 1'b1;
            wdata = 18'(next_val);
            if (tail - head < DEPTH) begin
                mdata[tail % DEPTH] = next_val;
                tail++;
            end
            next_val = (next_val + 7919) % 262144;
            @(negedge wclk);
            wen = 1'b0;
        end
    endtask

    task automatic pop(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            ren = 1'b1;
            @(negedge rclk);
            ren = 1'b0;
            if (tail - head > 0) begin
                last_rd = mdata[head % DEPTH];
                head++;
            end
            chk(req, "rdata", int'(rdata), last_rd);
        end
    endtask

    task automatic check_flags(input string tag);
        int cnt;
        cnt = tail - head;
        chk("R2", {tag, " full"},   int'(full),   int'(cnt == DEPTH));
        chk("R5", {tag, " afull"},  int'(afull),  int'(cnt >= DEPTH - af_m));
        chk("R4", {tag, " hfull"},  int'(hfull),  int'(cnt >= 257));
        chk("R6", {tag, " aempty"}, int'(aempty), int'(cnt <= ae_m));
        chk("R3", {tag, " empty"},  int'(empty),  int'(cnt == 0));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wen = 1'b0; ren = 1'b0; rt = 1'b0; af_ld = 1'b0; ae_ld = 1'b0;
        repeat (3) @(negedge wclk);
        rst_n = 1'b1;
        head = 0; tail = 0; af_m = 63; ae_m = 63; last_rd = 0;
        settle();
    endtask

    task automatic pulse_rt(input bit with_read);
        @(negedge rclk);
        rt  = 1'b1;
        ren = with_read;
        @(negedge rclk);
        rt  = 1'b0;
        ren = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        do_reset();
        // R10 reset state
        chk("R10", "rdata after reset", int'(rdata), 0);
        chk("R10", "empty after reset", int'(empty), 1);
        chk("R10", "aempty after reset", int'(aempty), 1);
        chk("R10", "full after reset", int'(full), 0);
        check_flags("R10 reset");

        // R8 replay before any wrap
        push(10);
        settle();
        check_flags("R8 ten held");
        pop(10, "R1");
        settle();
        check_flags("R8 drained");
        pulse_rt(1'b0);
        head = 0;
        repeat (3) @(negedge rclk);
        chk("R8", "empty after replay", int'(empty), 0);
        pop(4, "R8");
        pulse_rt(1'b1);
        chk("R8", "rdata held on replay with pull", int'(rdata), last_rd);
        head = 0;
        pop(10, "R8");
        settle();
        check_flags("R8 second drain");

        // Table walk
        do_reset();
        foreach (VECS[i]) begin
            push(VECS[i].nw);
            settle();
            pop(VECS[i].nr, "R1");
            settle();
            check_flags($sformatf("vec%0d", i));
        end

        // R9 replay ignored after wrap
        pulse_rt(1'b0);
        settle();
        chk("R9", "empty after ignored replay", int'(empty), 1);
        push(2);
        settle();
        pop(1, "R9");
        pulse_rt(1'b0);
        settle();
        check_flags("R9 one held");
        pop(1, "R9");

        // R9 reset re-enables replay
        do_reset();
        push(3);
        settle();
        pop(3, "R1");
        settle();
        pulse_rt(1'b0);
        head = 0;
        settle();
        chk("R9", "empty after replay post reset", int'(empty), 0);
        pop(3, "R9");
        settle();

        // R7 offset loads
        @(negedge wclk);
        af_ld = 1'b1; af_val = 9'd10;
        @(negedge wclk);
        af_ld = 1'b0;
        @(negedge rclk);
        ae_ld = 1'b1; ae_val = 9'd5;
        @(negedge rclk);
        ae_ld = 1'b0;
        af_m = 10; ae_m = 5;
        push(5);
        settle();
        check_flags("R7 five");
        chk("R7", "aempty at ae distance", int'(aempty), 1);
        push(1);
        settle();
        chk("R7", "aempty above ae distance", int'(aempty), 0);
        push(495);
        settle();
        chk("R7", "afull below threshold", int'(afull), 0);
        push(1);
        settle();
        chk("R7", "afull at threshold", int'(afull), 1);
        check_flags("R7 502");
        pop(502, "R1");
        settle();
        check_flags("R7 drained");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=0 exp=1");
            summary();
            $finish;
        end
    end
endmodule